// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a 20-bit physical frame number. The translation cache calls it after a miss. A request carries the address, a write flag and a user-mode flag. The walker reads one directory entry and then one table entry over a simple 32-bit memory port. When an accessed bit or dirty bit needs setting, it writes that entry back. It then reports either the frame or a page fault.

The address splits 10+10+12. Bits 31:22 pick one of 1024 directory words, each 4 bytes wide. Bits 21:12 pick one of 1024 table words. Bits 11:0 are the byte offset in the page, and the walker does not use them. The directory sits at the base input with its low 12 bits taken as zero.

On a fault, a held register captures three things: the linear address, whether the access was a write or from user mode, and whether the fault was for a missing entry or a broken protection rule.

Top module: `pt_walker`

## Requirements
- R1: The first memory read of a walk goes to `{dir_base[31:12], lin[31:22], 2'b00}`. The low 12 bits of `dir_base` have no effect. While `mem_req` is high and `mem_ack` is low, `mem_req` and `mem_addr` hold steady.
- R2: The second read of a walk goes to `{pde[31:12], lin[21:12], 2'b00}`, where `pde` is the directory word.
- R3: If the directory word has bit 0 (present) clear, the walk ends in a fault with `fault_prot`=0. The table word is never read.
- R4: If the directory word is present and bit 5 (accessed) is clear, the word is written back with bit 5 set and every other bit unchanged. Bit 6 (dirty) is never changed in a directory word. If bit 5 is already set, nothing is written.
- R5: If the table word has bit 0 clear, the walk ends in a fault with `fault_prot`=0.
- R6: With both words present, a user access (`req_user`=1) faults with `fault_prot`=1 if bit 2 (user) is clear in either word. A user write also faults with `fault_prot`=1 if bit 1 (writable) is clear in either word. Supervisor accesses ignore bits 1 and 2. The table word is not written on a fault.
- R7: On success, the table word is written back with bit 5 set and, for a write, bit 6 set. The write happens only if a bit actually changes.
- R8: On success, `done_valid` pulses for exactly one cycle, with `done_frame` equal to the table word's bits 31:12.
- R9: On a fault, `fault_valid` pulses for one cycle. At the same time, `fault_addr` loads the linear address, `fault_write` loads the write flag and `fault_user` loads the user flag. All four fault outputs stay unchanged until the next fault.
- R10: After reset the walker is idle: `busy`, `mem_req`, `done_valid` and `fault_valid` are 0, and `fault_addr` is 0.
- R11: `mem_we` is high only together with `mem_req`. `done_valid` and `fault_valid` are never high together, and neither is high while a memory access is pending. The walker ignores `req_valid` while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start a walk (taken when idle) |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Directory base; bits 11:0 ignored; stable during a walk |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| done_valid | output | 1 | One-cycle success pulse |
| done_frame | output | 20 | Physical frame number |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_addr | output | 32 | Held faulting linear address |
| fault_write | output | 1 | Held: faulting access was a write |
| fault_user | output | 1 | Held: faulting access was from user mode |
| fault_prot | output | 1 | Held: 1 = protection fault, 0 = not present |

## Verification
Some properties are checked on every cycle:
- the memory request and address stay steady until acknowledged;
- every write-back carries a set accessed bit;
- the done and fault pulses are exclusive and last one cycle;
- the fault register changes only together with a fault pulse.

Whether a particular combination of entry bits and access kind gives the right outcome, frame, fault kind, write-back value and write-back count can only be shown by the bench's scenarios. The bench sweeps every combination of the relevant directory bits, table bits, write flag and user flag, and checks each result against the rules above.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int LIN_W    = 32;
    localparam int DIR_BITS = 10;
    localparam int TBL_BITS = 10;
    localparam int OFF_BITS = 12;
    localparam int FRAME_W  = LIN_W - OFF_BITS;
    localparam int DIR_HI   = LIN_W - 1;
    localparam int DIR_LO   = LIN_W - DIR_BITS;
    localparam int TBL_HI   = DIR_LO - 1;
    localparam int TBL_LO   = OFF_BITS;

    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_DIR,
        ST_WR_DIR,
        ST_RD_TBL,
        ST_WR_TBL,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef struct packed {
        walk_st_e           st;
        logic [LIN_W-1:0]   lin;
        logic               wr;
        logic               usr;
        logic [LIN_W-1:0]   dir_ent;
        logic [LIN_W-1:0]   tbl_ent;
        logic [LIN_W-1:0]   flt_addr;
        logic               flt_wr;
        logic               flt_usr;
        logic               flt_prot;
    } walk_t;
endpackage

// File: rtl/pw_access_chk.sv
module pw_access_chk (
    input  logic dir_rw,
    input  logic dir_us,
    input  logic tbl_rw,
    input  logic tbl_us,
    input  logic is_write,
    input  logic is_user,
    output logic prot_fault
);
    logic user_ok;
    logic write_ok;

    always_comb begin
        user_ok    = dir_us & tbl_us;
        write_ok   = (dir_rw & tbl_rw) | ~is_write;
        prot_fault = is_user & ~(user_ok & write_ok);
    end
endmodule

// File: rtl/pw_flag_merge.sv
module pw_flag_merge
    import pw_pkg::*;
(
    input  logic [LIN_W-1:0] entry_in,
    input  logic             mark_dirty,
    output logic [LIN_W-1:0] entry_out,
    output logic             changed
);
    always_comb begin
        entry_out        = entry_in;
        entry_out[BIT_A] = 1'b1;
        if (mark_dirty) begin
            entry_out[BIT_D] = 1'b1;
        end
        changed = (entry_out != entry_in);
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [31:0]         req_lin,
    input  logic                req_write,
    input  logic                req_user,
    input  logic [31:0]         dir_base,
    output logic                busy,
    output logic                mem_req,
    output logic                mem_we,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    input  logic                mem_ack,
    input  logic [31:0]         mem_rdata,
    output logic                done_valid,
    output logic [19:0]         done_frame,
    output logic                fault_valid,
    output logic [31:0]         fault_addr,
    output logic                fault_write,
    output logic                fault_user,
    output logic                fault_prot
);
    walk_t s_d, s_q;

    logic [LIN_W-1:0] dir_new_d, tbl_new_d;
    logic             dir_chg_d, tbl_chg_d;
    logic             prot_d;

    // directory entry update: never marks dirty
    pw_flag_merge u_dir_merge (
        .entry_in   (mem_rdata),
        .mark_dirty (1'b0),
        .entry_out  (dir_new_d),
        .changed    (dir_chg_d)
    );

    pw_flag_merge u_tbl_merge (
        .entry_in   (mem_rdata),
        .mark_dirty (s_q.wr),
        .entry_out  (tbl_new_d),
        .changed    (tbl_chg_d)
    );

    pw_access_chk u_chk (
        .dir_rw     (s_q.dir_ent[BIT_RW]),
        .dir_us     (s_q.dir_ent[BIT_US]),
        .tbl_rw     (mem_rdata[BIT_RW]),
        .tbl_us     (mem_rdata[BIT_US]),
        .is_write   (s_q.wr),
        .is_user    (s_q.usr),
        .prot_fault (prot_d)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.lin = req_lin;
                    s_d.wr  = req_write;
                    s_d.usr = req_user;
                    s_d.st  = ST_RD_DIR;
                end
            end
            ST_RD_DIR: begin
                if (mem_ack) begin
                    s_d.dir_ent = mem_rdata;
                    if (!mem_rdata[BIT_P]) begin
                        s_d.st       = ST_FAULT;
                        s_d.flt_addr = s_q.lin;
                        s_d.flt_wr   = s_q.wr;
                        s_d.flt_usr  = s_q.usr;
                        s_d.flt_prot = 1'b0;
                    end else if (dir_chg_d) begin
                        s_d.dir_ent = dir_new_d;
                        s_d.st      = ST_WR_DIR;
                    end else begin
                        s_d.st = ST_RD_TBL;
                    end
                end
            end
            ST_WR_DIR: begin
                if (mem_ack) begin
                    s_d.st = ST_RD_TBL;
                end
            end
            ST_RD_TBL: begin
                if (mem_ack) begin
                    s_d.tbl_ent = mem_rdata;
                    if (!mem_rdata[BIT_P] || prot_d) begin
                        s_d.st       = ST_FAULT;
                        s_d.flt_addr = s_q.lin;
                        s_d.flt_wr   = s_q.wr;
                        s_d.flt_usr  = s_q.usr;
                        s_d.flt_prot = mem_rdata[BIT_P];
                    end else if (tbl_chg_d) begin
                        s_d.tbl_ent = tbl_new_d;
                        s_d.st      = ST_WR_TBL;
                    end else begin
                        s_d.st = ST_DONE;
                    end
                end
            end
            ST_WR_TBL: begin
                if (mem_ack) begin
                    s_d.st = ST_DONE;
                end
            end
            ST_DONE:  s_d.st = ST_IDLE;
            ST_FAULT: s_d.st = ST_IDLE;
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    logic dir_phase;
    always_comb begin
        dir_phase   = (s_q.st == ST_RD_DIR) || (s_q.st == ST_WR_DIR);
        busy        = (s_q.st != ST_IDLE);
        mem_req     = dir_phase || (s_q.st == ST_RD_TBL) || (s_q.st == ST_WR_TBL);
        mem_we      = (s_q.st == ST_WR_DIR) || (s_q.st == ST_WR_TBL);
        mem_addr    = dir_phase
                    ? {dir_base[31:OFF_BITS], s_q.lin[DIR_HI:DIR_LO], 2'b00}
                    : {s_q.dir_ent[31:OFF_BITS], s_q.lin[TBL_HI:TBL_LO], 2'b00};
        mem_wdata   = (s_q.st == ST_WR_DIR) ? s_q.dir_ent : s_q.tbl_ent;
        done_valid  = (s_q.st == ST_DONE);
        done_frame  = s_q.tbl_ent[31:OFF_BITS];
        fault_valid = (s_q.st == ST_FAULT);
        fault_addr  = s_q.flt_addr;
        fault_write = s_q.flt_wr;
        fault_user  = s_q.flt_usr;
        fault_prot  = s_q.flt_prot;
    end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        done_valid,
    input logic        fault_valid,
    input logic [31:0] fault_addr,
    input logic        fault_write,
    input logic        fault_user,
    input logic        fault_prot
);
    AST_WE_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req); // R11
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid)); // R11
    AST_NO_PULSE_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (!done_valid && !fault_valid)); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R1
    AST_WB_ACCESSED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_wdata[5]); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R8
    AST_FAULT_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_valid |-> ($stable(fault_addr) && $stable(fault_write)
                          && $stable(fault_user) && $stable(fault_prot))); // R9
endmodule

bind pt_walker pt_walker_chk u_chk_bind (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done_valid  (done_valid),
    .fault_valid (fault_valid),
    .fault_addr  (fault_addr),
    .fault_write (fault_write),
    .fault_user  (fault_user),
    .fault_prot  (fault_prot)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = 32'h0012_3ABC;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        done_valid, fault_valid, fault_write, fault_user, fault_prot;
    logic [19:0] done_frame;
    logic [31:0] fault_addr;

    always #4 clk = ~clk;

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user), .dir_base(dir_base),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done_valid(done_valid), .done_frame(done_frame), .fault_valid(fault_valid),
        .fault_addr(fault_addr), .fault_write(fault_write), .fault_user(fault_user),
        .fault_prot(fault_prot)
    );

    // two-word memory model with write and read recording
    logic [31:0] dir_a = '0, tbl_a = '0, dir_init = '0, tbl_init = '0;
    logic        clr = 1'b0;
    int          dir_wn, tbl_wn, tbl_rn, bad_n;
    logic [31:0] dir_wv, tbl_wv;

    always_comb begin
        mem_ack = mem_req;
        if (mem_addr == dir_a)      mem_rdata = (dir_wn != 0) ? dir_wv : dir_init;
        else if (mem_addr == tbl_a) mem_rdata = (tbl_wn != 0) ? tbl_wv : tbl_init;
        else                        mem_rdata = 32'hBAD0_BAD0;
    end

    always @(posedge clk) begin
        if (clr) begin
            dir_wn <= 0; tbl_wn <= 0; tbl_rn <= 0; bad_n <= 0;
            dir_wv <= '0; tbl_wv <= '0;
        end else if (mem_req) begin
            if (mem_addr == dir_a) begin
                if (mem_we) begin dir_wn <= dir_wn + 1; dir_wv <= mem_wdata; end
            end else if (mem_addr == tbl_a) begin
                if (mem_we) begin tbl_wn <= tbl_wn + 1; tbl_wv <= mem_wdata; end
                else tbl_rn <= tbl_rn + 1;
            end else begin
                bad_n <= bad_n + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    initial begin
        #1_400_000;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    logic [31:0] last_faddr = '0;
    logic [2:0]  last_fflags = '0;

    initial begin
        clr = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!busy && !mem_req && !done_valid && !fault_valid, "R10 idle",
            {28'd0, busy, mem_req, done_valid, fault_valid}, 32'd0);
        chk(fault_addr == 32'd0, "R10 fault_addr", fault_addr, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int c = 0; c < 2048; c++) begin
            logic [31:0] lin, pd, pt, exp_pd, exp_pt;
            logic [19:0] pfrm, tfrm;
            bit wr, usr, np, prot, okw, exp_pdw, exp_ptw;
            int wait_n;
            lin  = c * 32'h9E37_79B1 + 32'h1357;
            pfrm = 20'h80000 | 20'((c * 3) & 16'hFFFF);
            tfrm = 20'((c * 32'h2F1D) ^ 32'h5A5A5);
            wr   = c[9];
            usr  = c[10];
            pd = {pfrm, 12'h000};
            pd[0] = c[0]; pd[1] = c[1]; pd[2] = c[2]; pd[5] = c[3];
            pd[6] = c[3] ^ c[5]; pd[9] = c[0];
            pt = {tfrm, 12'h000};
            pt[0] = c[4]; pt[1] = c[5]; pt[2] = c[6]; pt[5] = c[7];
            pt[6] = c[8]; pt[10] = c[1];
            dir_init = pd; tbl_init = pt;
            dir_a = {20'h00123, lin[31:22], 2'b00};
            tbl_a = {pfrm, lin[21:12], 2'b00};
            clr = 1'b1;
            @(negedge clk);
            clr = 1'b0;
            req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            req_lin = ~lin; // ignored while busy (R11)
            wait_n = 0;
            while (!done_valid && !fault_valid && wait_n < 20) begin
                @(negedge clk);
                wait_n++;
            end

            np      = !pd[0] || !pt[0];
            prot    = !np && usr && (!pd[2] || !pt[2] || (wr && (!pd[1] || !pt[1])));
            okw     = !np && !prot;
            exp_pdw = pd[0] && !pd[5];
            exp_pd  = pd | 32'h20;
            exp_pt  = pt | 32'h20 | (wr ? 32'h40 : 32'h0);
            exp_ptw = okw && (exp_pt != pt);

            chk(done_valid == okw && fault_valid == !okw, "R3/R5/R6 outcome",
                {30'd0, done_valid, fault_valid}, {30'd0, okw, !okw});
            chk(bad_n == 0, "R1/R2 entry address", bad_n, 0);
            chk(tbl_rn == (pd[0] ? 1 : 0), "R3 table read count", tbl_rn, pd[0] ? 1 : 0);
            chk(dir_wn == (exp_pdw ? 1 : 0), "R4 directory write count", dir_wn,
                exp_pdw ? 1 : 0);
            if (exp_pdw) chk(dir_wv == exp_pd, "R4 directory write value", dir_wv, exp_pd);
            chk(tbl_wn == (exp_ptw ? 1 : 0), "R7 table write count", tbl_wn,
                exp_ptw ? 1 : 0);
            if (exp_ptw) chk(tbl_wv == exp_pt, "R7 table write value", tbl_wv, exp_pt);
            if (okw) begin
                chk(done_frame == tfrm, "R8 frame", {12'd0, done_frame}, {12'd0, tfrm});
                chk(fault_addr == last_faddr, "R9 fault register held",
                    fault_addr, last_faddr);
            end else begin
                last_faddr  = lin;
                last_fflags = {wr, usr, prot};
                chk(fault_addr == lin, "R9 fault address", fault_addr, lin);
                chk({fault_write, fault_user, fault_prot} == last_fflags,
                    "R6/R9 fault flags", {29'd0, fault_write, fault_user, fault_prot},
                    {29'd0, last_fflags});
            end
            @(negedge clk);
            chk(!done_valid && !fault_valid && !busy, "R8 single pulse",
                {30'd0, done_valid, fault_valid}, 32'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule